// File: doc/BRIEF.md
# Processor Write Buffer Controller

The block sits between a processor store port and an external memory write bus. Stores that may be buffered are placed in a small queue of line-sized entries, and the processor is released at once. A later bus engine writes each entry out as one full-line transaction, carrying per-byte enables. Stores that may not be buffered, and every store made while buffering is off, hold the processor. The processor stays held until the queue and the bus are idle and that store has itself been written and acknowledged. A data cache copy-back port pushes whole dirty lines into the same queue whether buffering is on or off. A drain handshake lets software wait until every queued write has reached memory.

Buffering is on only while both the translation-enable bit and the buffer-enable bit of the control inputs are high. Turning buffering off never discards queued entries. A store flagged as a continuation of a store-multiple sequence is folded into the newest queued entry when it targets the same line and that entry is still waiting. Any other store opens a new entry.

The processor side is a four-state machine:
- `CPU_IDLE` samples a request. A buffered store is merged or pushed and moves to `CPU_DONE`. When the queue is full and no merge is possible, the machine stays in `CPU_IDLE`, which stalls the processor. Any other store moves to `CPU_SYNC_WAIT`.
- `CPU_SYNC_WAIT` waits until the queue is empty and the bus is idle. It then pushes the store as a closed entry and moves to `CPU_SYNC_BUS`.
- `CPU_SYNC_BUS` waits for the bus acknowledge and then moves to `CPU_DONE`.
- `CPU_DONE` raises the completion pulse for one cycle and returns to `CPU_IDLE`.

The bus side is a two-state machine:
- `RET_IDLE` pops the oldest entry into output registers when the queue is not empty, and moves to `RET_BUSY`.
- `RET_BUSY` holds the request until the acknowledge arrives, and then returns to `RET_IDLE`.

Top module: `wbuf_ctrl`

## Requirements
- R1: After reset, `bus_req` is 0, `cpu_done` is 0, and `drain_done` is 0 while `drain_req` is 0.
- R2: With buffering on, a store with `cpu_bufable`=1 is completed by a single-cycle `cpu_done` pulse one to two cycles after the request is presented, without waiting for any bus acknowledge.
- R3: Buffering is on only when `ctl_mmu_on`=1 and `ctl_wbuf_on`=1. With either bit low, a store with `cpu_bufable`=1 completes only after its own bus transaction has been acknowledged.
- R4: A store with `cpu_bufable`=0 first waits until every earlier queued write has been acknowledged on the bus. It is then written as its own transaction, and `cpu_done` follows that transaction's acknowledge.
- R5: A store with `cpu_stm`=1 whose line matches the newest queued entry, while that entry has not yet been taken by the bus, is merged into that entry, so several words leave in one transaction with their combined byte enables. A store with `cpu_stm`=0, or one aimed at a different line, opens a new entry.
- R6: Entries leave in arrival order, with one transaction per entry. `bus_req` and its address, data and enables stay steady until `bus_ack`, and `bus_req` drops in the cycle after an acknowledge.
- R7: The queue holds 8 entries. When it is full, a buffered store gets no `cpu_done` until an entry has been retired.
- R8: Clearing `ctl_wbuf_on` leaves queued entries in place, and each one is still written to the bus.
- R9: `drain_done` is 1 exactly when `drain_req` is 1, the queue is empty and no bus transaction is outstanding.
- R10: A copy-back (`cb_req`) is accepted (`cb_ack`=1) even while buffering is off. It becomes one transaction with the whole line and all 32 byte enables set.
- R11: A single-word store to byte address A is written with bus address A with bits 4:0 cleared. Its data appears in word slot A[4:2], at `bus_data` bits slot*32+31..slot*32, and its four enables at `bus_be` bits slot*4+3..slot*4. All other enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | Store request, held until `cpu_done` |
| cpu_waddr | input | 30 | Word address of the store |
| cpu_wdata | input | 32 | Store data |
| cpu_wbe | input | 4 | Byte enables of the store |
| cpu_bufable | input | 1 | Store may be buffered |
| cpu_stm | input | 1 | Store continues the previous store-multiple word |
| cpu_done | output | 1 | One-cycle completion pulse; the processor is held while low |
| ctl_mmu_on | input | 1 | Translation-enable control bit |
| ctl_wbuf_on | input | 1 | Buffer-enable control bit |
| drain_req | input | 1 | Drain command |
| drain_done | output | 1 | Queue empty and bus idle while draining |
| cb_req | input | 1 | Copy-back line offered |
| cb_tag | input | 27 | Line address of the copy-back |
| cb_data | input | 256 | Copy-back line data |
| cb_ack | output | 1 | Copy-back taken this cycle |
| bus_req | output | 1 | Bus write request |
| bus_addr | output | 32 | Line-aligned bus byte address |
| bus_data | output | 256 | Line data |
| bus_be | output | 32 | Per-byte enables of the line |
| bus_ack | input | 1 | Bus write acknowledge |

## Verification
On every cycle, the in-line properties check the following:
- the completion pulse lasts one cycle;
- the queue is never pushed while full, merged while empty or popped while empty;
- a pending bus request holds its address and enables until acknowledged, then falls;
- no request is outstanding while the drain is reported done.

Only the bench scenarios can show the rest:
- buffered stores finish without the bus, while unbuffered or disabled-mode stores finish only after their own acknowledge;
- merged store-multiple words leave as one transaction;
- a full queue stalls the processor;
- entries survive disabling;
- copy-backs pass while disabled;
- words and enables land in the right slots.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

    // processor-side sequencing
    typedef enum logic [1:0] {
        CPU_IDLE,
        CPU_SYNC_WAIT,
        CPU_SYNC_BUS,
        CPU_DONE
    } cpu_state_e;

    // bus retirement sequencing
    typedef enum logic {
        RET_IDLE,
        RET_BUSY
    } ret_state_e;

endpackage

// File: rtl/wbuf_fifo.sv
module wbuf_fifo #(
    parameter int TAG_W  = 27,
    parameter int WORD_W = 32,
    parameter int WORDS  = 8,
    parameter int DEPTH  = 8,
    localparam int WBE    = WORD_W / 8,
    localparam int LINE_W = WORD_W * WORDS,
    localparam int BE_W   = WBE * WORDS,
    localparam int OFF_W  = $clog2(WORDS),
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [TAG_W-1:0]  push_tag,
    input  logic [LINE_W-1:0] push_data,
    input  logic [BE_W-1:0]   push_be,
    input  logic              push_open,
    input  logic              merge,
    input  logic [OFF_W-1:0]  merge_slot,
    input  logic [WORD_W-1:0] merge_word,
    input  logic [WBE-1:0]    merge_wbe,
    input  logic              pop,
    output logic [TAG_W-1:0]  head_tag,
    output logic [LINE_W-1:0] head_data,
    output logic [BE_W-1:0]   head_be,
    output logic [TAG_W-1:0]  tail_tag,
    output logic              tail_open,
    output logic              empty,
    output logic              full,
    output logic              single
);

    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

    logic [TAG_W-1:0]  tag_q  [DEPTH];
    logic [LINE_W-1:0] data_q [DEPTH];
    logic [BE_W-1:0]   be_q   [DEPTH];
    logic [DEPTH-1:0]  open_q;
    logic [PTR_W-1:0]  wr_q, rd_q, tail_idx;
    logic [CNT_W-1:0]  count_q;

    assign tail_idx  = (wr_q == '0) ? LAST_IDX : wr_q - 1'b1;
    assign empty     = (count_q == '0);
    assign full      = (count_q == CNT_W'(DEPTH));
    assign single    = (count_q == CNT_W'(1));
    assign head_tag  = tag_q[rd_q];
    assign head_data = data_q[rd_q];
    assign head_be   = be_q[rd_q];
    assign tail_tag  = tag_q[tail_idx];
    assign tail_open = open_q[tail_idx];

    // pointers and occupancy
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q    <= '0;
            rd_q    <= '0;
            count_q <= '0;
        end else begin
            if (push) wr_q <= (wr_q == LAST_IDX) ? '0 : wr_q + 1'b1;
            if (pop)  rd_q <= (rd_q == LAST_IDX) ? '0 : rd_q + 1'b1;
            unique case ({push, pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    // merge permission per entry
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_q <= '0;
        end else if (push) begin
            open_q[wr_q] <= push_open;
        end
    end

    // entry storage; a merge touches only the selected word's enabled bytes
    always_ff @(posedge clk) begin
        if (push) begin
            tag_q[wr_q]  <= push_tag;
            data_q[wr_q] <= push_data;
            be_q[wr_q]   <= push_be;
        end
        if (merge) begin
            for (int s = 0; s < WORDS; s++) begin
                if (merge_slot == OFF_W'(s)) begin
                    for (int b = 0; b < WBE; b++) begin
                        if (merge_wbe[b]) begin
                            data_q[tail_idx][s*WORD_W + b*8 +: 8] <= merge_word[b*8 +: 8];
                            be_q[tail_idx][s*WBE + b] <= 1'b1;
                        end
                    end
                end
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push) else $error("push into full queue"); // R7
    AST_MERGE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        merge |-> !empty) else $error("merge without entry"); // R5
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty) else $error("pop from empty queue"); // R6

endmodule

// File: rtl/wbuf_retire.sv
module wbuf_retire
    import wbuf_pkg::*;
#(
    parameter int TAG_W  = 27,
    parameter int LOW_W  = 5,
    parameter int LINE_W = 256,
    parameter int BE_W   = 32,
    localparam int ADDR_W = TAG_W + LOW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_empty,
    input  logic [TAG_W-1:0]  head_tag,
    input  logic [LINE_W-1:0] head_data,
    input  logic [BE_W-1:0]   head_be,
    output logic              pop,
    output logic              busy,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [LINE_W-1:0] bus_data,
    output logic [BE_W-1:0]   bus_be,
    input  logic              bus_ack
);

    ret_state_e        state_q, state_d;
    logic [TAG_W-1:0]  tag_q;
    logic [LINE_W-1:0] data_q;
    logic [BE_W-1:0]   be_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RET_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RET_IDLE: if (!fifo_empty) state_d = RET_BUSY;
            RET_BUSY: if (bus_ack)     state_d = RET_IDLE;
            default:  state_d = RET_IDLE;
        endcase
    end

    always_comb begin
        pop     = 1'b0;
        busy    = 1'b0;
        bus_req = 1'b0;
        unique case (state_q)
            RET_IDLE: pop = !fifo_empty;
            RET_BUSY: begin
                busy    = 1'b1;
                bus_req = 1'b1;
            end
            default: ;
        endcase
    end

    // the popped entry is held here for the whole transaction
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tag_q  <= '0;
            data_q <= '0;
            be_q   <= '0;
        end else if (pop) begin
            tag_q  <= head_tag;
            data_q <= head_data;
            be_q   <= head_be;
        end
    end

    assign bus_addr = {tag_q, {LOW_W{1'b0}}};
    assign bus_data = data_q;
    assign bus_be   = be_q;

    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_be))
        else $error("bus request changed before acknowledge"); // R6
    AST_BUS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_ack |=> !bus_req) else $error("request held past acknowledge"); // R6

endmodule

// File: rtl/wbuf_ctrl.sv
module wbuf_ctrl
    import wbuf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32,
    parameter int WORDS  = 8,
    parameter int DEPTH  = 8,
    localparam int WBE    = WORD_W / 8,
    localparam int LINE_W = WORD_W * WORDS,
    localparam int BE_W   = WBE * WORDS,
    localparam int OFF_W  = $clog2(WORDS),
    localparam int BOFF_W = $clog2(WBE),
    localparam int WA_W   = ADDR_W - BOFF_W,
    localparam int TAG_W  = WA_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic [WA_W-1:0]   cpu_waddr,
    input  logic [WORD_W-1:0] cpu_wdata,
    input  logic [WBE-1:0]    cpu_wbe,
    input  logic              cpu_bufable,
    input  logic              cpu_stm,
    output logic              cpu_done,
    input  logic              ctl_mmu_on,
    input  logic              ctl_wbuf_on,
    input  logic              drain_req,
    output logic              drain_done,
    input  logic              cb_req,
    input  logic [TAG_W-1:0]  cb_tag,
    input  logic [LINE_W-1:0] cb_data,
    output logic              cb_ack,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [LINE_W-1:0] bus_data,
    output logic [BE_W-1:0]   bus_be,
    input  logic              bus_ack
);

    cpu_state_e        state_q, state_d;
    logic              buf_on, buffered, can_merge;
    logic [TAG_W-1:0]  cur_tag;
    logic [OFF_W-1:0]  cur_slot;
    logic              cpu_push, cpu_merge, push_open;
    logic [LINE_W-1:0] one_data;
    logic [BE_W-1:0]   one_be;
    logic              fifo_push;
    logic [TAG_W-1:0]  fifo_tag;
    logic [LINE_W-1:0] fifo_data;
    logic [BE_W-1:0]   fifo_be;
    logic              fifo_empty, fifo_full, fifo_single, tail_open;
    logic [TAG_W-1:0]  tail_tag, head_tag;
    logic [LINE_W-1:0] head_data;
    logic [BE_W-1:0]   head_be;
    logic              ret_pop, ret_busy;

    assign buf_on   = ctl_mmu_on && ctl_wbuf_on;
    assign buffered = cpu_bufable && buf_on;
    assign cur_tag  = cpu_waddr[WA_W-1:OFF_W];
    assign cur_slot = cpu_waddr[OFF_W-1:0];

    // merge only into a waiting newest entry of the same line
    assign can_merge = cpu_stm && !fifo_empty && tail_open &&
                       (tail_tag == cur_tag) && !(ret_pop && fifo_single);

    // place one store word into its slot of a line
    for (genvar g = 0; g < WORDS; g++) begin : g_slot
        assign one_data[g*WORD_W +: WORD_W] = (cur_slot == OFF_W'(g)) ? cpu_wdata : '0;
        assign one_be[g*WBE +: WBE]         = (cur_slot == OFF_W'(g)) ? cpu_wbe   : '0;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CPU_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CPU_IDLE: begin
                if (cpu_req) begin
                    if (!buffered)                    state_d = CPU_SYNC_WAIT;
                    else if (can_merge || !fifo_full) state_d = CPU_DONE;
                end
            end
            CPU_SYNC_WAIT: if (fifo_empty && !ret_busy) state_d = CPU_SYNC_BUS;
            CPU_SYNC_BUS:  if (bus_req && bus_ack)      state_d = CPU_DONE;
            CPU_DONE:      state_d = CPU_IDLE;
            default:       state_d = CPU_IDLE;
        endcase
    end

    // outputs of the processor-side machine
    always_comb begin
        cpu_push  = 1'b0;
        cpu_merge = 1'b0;
        push_open = 1'b0;
        cpu_done  = 1'b0;
        unique case (state_q)
            CPU_IDLE: begin
                if (cpu_req && buffered) begin
                    if (can_merge) begin
                        cpu_merge = 1'b1;
                    end else if (!fifo_full) begin
                        cpu_push  = 1'b1;
                        push_open = 1'b1;
                    end
                end
            end
            CPU_SYNC_WAIT: cpu_push = fifo_empty && !ret_busy;
            CPU_DONE:      cpu_done = 1'b1;
            default: ;
        endcase
    end

    // the processor side owns the push port; copy-backs take free cycles
    assign cb_ack     = cb_req && !fifo_full && !cpu_push;
    assign fifo_push  = cpu_push || cb_ack;
    assign fifo_tag   = cpu_push ? cur_tag  : cb_tag;
    assign fifo_data  = cpu_push ? one_data : cb_data;
    assign fifo_be    = cpu_push ? one_be   : '1;
    assign drain_done = drain_req && fifo_empty && !ret_busy;

    wbuf_fifo #(
        .TAG_W (TAG_W),
        .WORD_W(WORD_W),
        .WORDS (WORDS),
        .DEPTH (DEPTH)
    ) i_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (fifo_push),
        .push_tag  (fifo_tag),
        .push_data (fifo_data),
        .push_be   (fifo_be),
        .push_open (push_open),
        .merge     (cpu_merge),
        .merge_slot(cur_slot),
        .merge_word(cpu_wdata),
        .merge_wbe (cpu_wbe),
        .pop       (ret_pop),
        .head_tag  (head_tag),
        .head_data (head_data),
        .head_be   (head_be),
        .tail_tag  (tail_tag),
        .tail_open (tail_open),
        .empty     (fifo_empty),
        .full      (fifo_full),
        .single    (fifo_single)
    );

    wbuf_retire #(
        .TAG_W (TAG_W),
        .LOW_W (OFF_W + BOFF_W),
        .LINE_W(LINE_W),
        .BE_W  (BE_W)
    ) i_retire (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_empty(fifo_empty),
        .head_tag  (head_tag),
        .head_data (head_data),
        .head_be   (head_be),
        .pop       (ret_pop),
        .busy      (ret_busy),
        .bus_req   (bus_req),
        .bus_addr  (bus_addr),
        .bus_data  (bus_data),
        .bus_be    (bus_be),
        .bus_ack   (bus_ack)
    );

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done) else $error("completion longer than one cycle"); // R2
    AST_DRAIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        drain_done |-> !bus_req) else $error("drain reported with bus busy"); // R9

endmodule

// File: tb/test_wbuf_ctrl.sv
module test_wbuf_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int ACK_LAT    = 2;
    localparam int WATCHDOG   = 150000;

    typedef struct packed {
        logic        mmu;
        logic        wb;
        logic        bufable;
        logic [31:0] addr;
        logic [31:0] data;
        logic [3:0]  be;
        logic        sync;
    } vec_t;

    localparam vec_t VECS [0:7] = '{
        '{1'b1, 1'b1, 1'b1, 32'h1000_0004, 32'h1111_1111, 4'hF, 1'b0},
        '{1'b1, 1'b1, 1'b0, 32'h1000_0040, 32'h2222_2222, 4'hF, 1'b1},
        '{1'b0, 1'b1, 1'b1, 32'h2000_0008, 32'h3333_3333, 4'h3, 1'b1},
        '{1'b1, 1'b0, 1'b1, 32'h2000_001C, 32'h4444_4444, 4'hC, 1'b1},
        '{1'b1, 1'b1, 1'b1, 32'h3000_0010, 32'h5555_5555, 4'h1, 1'b0},
        '{1'b1, 1'b1, 1'b1, 32'h3000_0030, 32'h6666_6666, 4'hF, 1'b0},
        '{1'b1, 1'b1, 1'b0, 32'h3000_0044, 32'h7777_7777, 4'hF, 1'b1},
        '{1'b1, 1'b1, 1'b1, 32'h4000_0000, 32'h8888_8888, 4'h8, 1'b0}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cpu_req = 1'b0;
    logic [29:0]  cpu_waddr = '0;
    logic [31:0]  cpu_wdata = '0;
    logic [3:0]   cpu_wbe = '0;
    logic         cpu_bufable = 1'b0;
    logic         cpu_stm = 1'b0;
    logic         cpu_done;
    logic         ctl_mmu_on = 1'b0;
    logic         ctl_wbuf_on = 1'b0;
    logic         drain_req = 1'b0;
    logic         drain_done;
    logic         cb_req = 1'b0;
    logic [26:0]  cb_tag = '0;
    logic [255:0] cb_data = '0;
    logic         cb_ack;
    logic         bus_req;
    logic [31:0]  bus_addr;
    logic [255:0] bus_data;
    logic [31:0]  bus_be;
    logic         bus_ack = 1'b0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int lat = 0;
    bit ack_en = 1'b1;
    int log_n = 0;
    logic [31:0]  log_addr [64];
    logic [255:0] log_data [64];
    logic [31:0]  log_be   [64];

    wbuf_ctrl i_wbuf_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_waddr(cpu_waddr), .cpu_wdata(cpu_wdata),
        .cpu_wbe(cpu_wbe), .cpu_bufable(cpu_bufable), .cpu_stm(cpu_stm),
        .cpu_done(cpu_done),
        .ctl_mmu_on(ctl_mmu_on), .ctl_wbuf_on(ctl_wbuf_on),
        .drain_req(drain_req), .drain_done(drain_done),
        .cb_req(cb_req), .cb_tag(cb_tag), .cb_data(cb_data), .cb_ack(cb_ack),
        .bus_req(bus_req), .bus_addr(bus_addr), .bus_data(bus_data),
        .bus_be(bus_be), .bus_ack(bus_ack)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // memory model: acknowledges after a fixed latency and logs each write
    always @(negedge clk) begin
        if (bus_ack) begin
            bus_ack <= 1'b0;
        end else if (bus_req && ack_en) begin
            if (lat == ACK_LAT) begin
                bus_ack <= 1'b1;
                log_addr[log_n] <= bus_addr;
                log_data[log_n] <= bus_data;
                log_be[log_n]   <= bus_be;
                log_n <= log_n + 1;
                lat <= 0;
            end else begin
                lat <= lat + 1;
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog (all requirements): cycles %0d expected below %0d", cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic issue(logic [31:0] baddr, logic [31:0] data, logic [3:0] be,
                         logic bufable, logic stm);
        cpu_waddr   = baddr[31:2];
        cpu_wdata   = data;
        cpu_wbe     = be;
        cpu_bufable = bufable;
        cpu_stm     = stm;
        cpu_req     = 1'b1;
    endtask

    task automatic wait_done(int limit, output int cyc);
        cyc = -1;
        for (int i = 1; i <= limit; i++) begin
            @(negedge clk);
            if (cpu_done) begin
                cyc = i;
                cpu_req = 1'b0;
                break;
            end
        end
    endtask

    task automatic write_buf(logic [31:0] baddr, logic [31:0] data, logic stm);
        int c;
        issue(baddr, data, 4'hF, 1'b1, stm);
        wait_done(200, c);
        chk("R2 buffered store latency", 64'(c >= 1 && c <= 2), 64'd1);
    endtask

    task automatic wait_drain();
        drain_req = 1'b1;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (drain_done) break;
        end
        chk("R9 drain completes", 64'(drain_done), 64'd1);
        drain_req = 1'b0;
    endtask

    task automatic check_txn(int idx, logic [31:0] baddr, logic [31:0] word,
                             logic [3:0] be, string tag);
        int slot;
        slot = int'(baddr[4:2]);
        chk({tag, " R11 address"}, 64'(log_addr[idx]), 64'(baddr & 32'hFFFF_FFE0));
        chk({tag, " R11 enables"}, 64'(log_be[idx]), 64'(32'(be) << (slot * 4)));
        chk({tag, " R11 data word"}, 64'(log_data[idx][slot*32 +: 32]), 64'(word));
    endtask

    initial begin
        int c;
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 bus_req after reset", 64'(bus_req), 64'd0);
        chk("R1 cpu_done after reset", 64'(cpu_done), 64'd0);
        chk("R1 drain_done after reset", 64'(drain_done), 64'd0);
        drain_req = 1'b1;
        #1;
        chk("R9 drain_done on empty buffer", 64'(drain_done), 64'd1);
        @(negedge clk);
        drain_req = 1'b0;

        // table walk: buffered vs synchronous completion (R2 R3 R4)
        for (int i = 0; i < 8; i++) begin
            ctl_mmu_on  = VECS[i].mmu;
            ctl_wbuf_on = VECS[i].wb;
            issue(VECS[i].addr, VECS[i].data, VECS[i].be, VECS[i].bufable, 1'b0);
            wait_done(400, c);
            if (VECS[i].sync) begin
                chk("R3 R4 synchronous store completed", 64'(c > 0), 64'd1);
                chk("R3 R4 transactions logged at completion", 64'(log_n), 64'(i + 1));
            end else begin
                chk("R2 buffered store latency", 64'(c >= 1 && c <= 2), 64'd1);
            end
        end
        wait_drain();
        chk("R6 one transaction per table store", 64'(log_n), 64'd8);
        for (int i = 0; i < 8; i++)
            check_txn(i, VECS[i].addr, VECS[i].data, VECS[i].be, "R6 table order");

        // R5 merging of store-multiple words
        ctl_mmu_on  = 1'b1;
        ctl_wbuf_on = 1'b1;
        base   = log_n;
        ack_en = 1'b0;
        write_buf(32'h6000_0000, 32'hAAAA_0000, 1'b0);
        write_buf(32'h5000_0000, 32'hB000_0000, 1'b0);
        write_buf(32'h5000_0004, 32'hB000_0001, 1'b1);
        write_buf(32'h5000_0008, 32'hB000_0002, 1'b1);
        write_buf(32'h5000_0020, 32'hC000_0000, 1'b1);
        write_buf(32'h5000_0024, 32'hD000_0001, 1'b0);
        repeat (5) @(negedge clk);
        chk("R6 request held without acknowledge", 64'(bus_req), 64'd1);
        chk("R6 nothing retired without acknowledge", 64'(log_n), 64'(base));
        drain_req = 1'b1;
        #1;
        chk("R9 drain_done low while busy", 64'(drain_done), 64'd0);
        drain_req = 1'b0;
        ack_en = 1'b1;
        wait_drain();
        chk("R5 merged entries give four transactions", 64'(log_n), 64'(base + 4));
        check_txn(base, 32'h6000_0000, 32'hAAAA_0000, 4'hF, "R5 blocker");
        chk("R5 merged address", 64'(log_addr[base+1]), 64'h5000_0000);
        chk("R5 merged enables", 64'(log_be[base+1]), 64'h0000_0FFF);
        chk("R5 merged data", 64'(log_data[base+1][95:64]), 64'hB000_0002);
        chk("R5 merged data low", 64'(log_data[base+1][63:0]), 64'hB000_0001_B000_0000);
        check_txn(base + 2, 32'h5000_0020, 32'hC000_0000, 4'hF, "R5 new line");
        check_txn(base + 3, 32'h5000_0024, 32'hD000_0001, 4'hF, "R5 no stm flag");

        // R7 full queue stalls the processor
        base   = log_n;
        ack_en = 1'b0;
        write_buf(32'h6000_0100, 32'h0000_00F0, 1'b0);
        for (int k = 0; k < 8; k++)
            write_buf(32'h8000_0000 + 32'(k * 32), 32'h8100_0000 + 32'(k), 1'b0);
        issue(32'h8000_1000, 32'h9999_9999, 4'hF, 1'b1, 1'b0);
        wait_done(12, c);
        chk("R7 no completion while full", 64'(c == -1), 64'd1);
        ack_en = 1'b1;
        wait_done(400, c);
        chk("R7 completion after retire", 64'(c > 0), 64'd1);
        wait_drain();
        chk("R7 all ten entries retired", 64'(log_n), 64'(base + 10));
        check_txn(base + 1, 32'h8000_0000, 32'h8100_0000, 4'hF, "R6 first queued");
        check_txn(base + 9, 32'h8000_1000, 32'h9999_9999, 4'hF, "R6 last queued");

        // R8 disabling keeps queued entries
        base   = log_n;
        ack_en = 1'b0;
        write_buf(32'h6000_0200, 32'h0000_0001, 1'b0);
        write_buf(32'hA000_0000, 32'hA1A1_A1A1, 1'b0);
        write_buf(32'hA000_0060, 32'hA2A2_A2A2, 1'b0);
        ctl_wbuf_on = 1'b0;
        repeat (5) @(negedge clk);
        ack_en = 1'b1;
        wait_drain();
        chk("R8 entries retired after disable", 64'(log_n), 64'(base + 3));
        check_txn(base + 2, 32'hA000_0060, 32'hA2A2_A2A2, 4'hF, "R8 last entry");

        // R10 copy-back while disabled
        base       = log_n;
        ctl_mmu_on = 1'b0;
        cb_tag     = 27'h070_0001;
        for (int w = 0; w < 8; w++) cb_data[w*32 +: 32] = 32'hCB00_0000 + 32'(w);
        cb_req = 1'b1;
        #1;
        chk("R10 copy-back accepted while disabled", 64'(cb_ack), 64'd1);
        @(negedge clk);
        cb_req = 1'b0;
        wait_drain();
        chk("R10 copy-back transaction count", 64'(log_n), 64'(base + 1));
        chk("R10 copy-back address", 64'(log_addr[base]), 64'h0E00_0020);
        chk("R10 copy-back enables", 64'(log_be[base]), 64'hFFFF_FFFF);
        chk("R10 copy-back data", 64'(log_data[base] == cb_data), 64'd1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule